// File: doc/BRIEF.md
# Cost-to-Go Processing Element Array

This block is a row of identical processing elements, one for each time state of a dynamic-programming stage. All of them obey one broadcast instruction stream. Each element holds an accumulator, a data register that can move one position toward the lower state index, a small multiplier store indexed by machine type, and a stack of decision bits. With these the array does three jobs. It builds windowed stage costs by shifting and accumulating. It adds a per-state cost-to-go vector. It runs a compare chain that passes a token from element to element. At each step the chain keeps the running minimum and records which of the two compared costs won.

The instruction port follows valid/ready. `ins_ready` is always high, so the array never applies back-pressure. Every beat with `ins_valid` high executes on the next rising edge, and a beat with `ins_valid` low has no effect. Arrays can be chained to cover a longer time horizon. The lowest element of an upper array feeds the top element of the array below it, through `casc_lo_dat`/`casc_lo_tok` to `casc_hi_dat`/`casc_hi_tok`. A token that crosses between arrays costs one idle compare cycle.

Opcodes in `ins_op` are: 0 no-op, 1 clear accumulators, 2 load data registers from store[`ins_type`], 3 add-and-shift, 4 add cost-to-go, 5 set window, 6 compare step, 7 pop stacks, 8 write store, 9 add to store, 10 subtract from store, 11 empty stacks. Any other code does nothing. For opcode 5 the fields are: upper bound = `ins_pe`, lower bound = `ins_dat[PW-1:0]`, seed bit = `ins_dat[CW-1]`.

Top module: `dpc_array`

## Requirements
- R1: After reset every accumulator reads 0, every `flag_top` bit is 0, `casc_lo_tok` and `casc_lo_dat` are 0, and `ins_ready` is 1.
- R2: Opcode 8 writes `ins_dat` into store entry `ins_type` of element `ins_pe`. Opcode 2 copies store[`ins_type`] into the data register of every element.
- R3: Opcode 3 adds each data register into its accumulator. In the same cycle it moves each data register from element i+1 to element i. The top element takes `casc_hi_dat`, and `casc_lo_dat` shows the old register of element 0 on the next cycle. The sequence clear, load, then P add-and-shift steps leaves element i holding the sum of store entries i to i+P-1.
- R4: Every accumulation saturates at 2^CW-1 and never wraps.
- R5: Opcode 4 adds slice i of `ctg_flat` (bits i*CW upward) into the accumulator of element i.
- R6: Opcode 5 enables elements lo..hi and disables all others. With the seed bit set, it places the token at element hi and loads that element's data register with 2^CW-1. A seed-clear window places no token.
- R7: Opcode 6 acts only in the element holding the token. That element writes min(acc, data register) into its accumulator and pushes flag = (acc <= data register), so a tie gives 1. It passes the minimum and the token to element i-1 if that element is enabled; otherwise the chain ends. A compare step with no token changes nothing.
- R8: When element 0 executes a compare step, `casc_lo_tok` is 1 for exactly the next cycle and `casc_lo_dat` then shows the minimum.
- R9: A cycle with `casc_hi_tok` high gives the token and `casc_hi_dat` to the top element, if that element is enabled.
- R10: The decision stacks are LIFO with SDEPTH entries. `flag_top` shows the top bit of each stack, or 0 when the stack is empty. Opcode 7 pops every non-empty stack. A push to a full stack is dropped. Opcode 11 empties all stacks.
- R11: Opcodes 9 and 10 add or subtract `ins_dat` on store entry `ins_type` of element `ins_pe`, clamping to the range 0 to 2^CW-1.
- R12: A beat with `ins_valid` low changes no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction beat present |
| ins_ready | output | 1 | Always 1 |
| ins_op | input | 4 | Opcode |
| ins_type | input | TW | Machine-type index |
| ins_pe | input | PW | Target element or window upper bound |
| ins_dat | input | CW | Immediate data or window lower bound / seed |
| ctg_flat | input | NPE*CW | Cost-to-go per state |
| casc_hi_dat | input | CW | Data from the array above |
| casc_hi_tok | input | 1 | Token from the array above |
| casc_lo_dat | output | CW | Data to the array below |
| casc_lo_tok | output | 1 | Token to the array below |
| acc_flat | output | NPE*CW | All accumulators |
| flag_top | output | NPE | Top decision bit of each stack |

## Verification
A misplaced token or a wrong enable shows up on the next compare cycle, either as an accumulator that does not hold the expected running minimum or as a `flag_top` bit set in the wrong element. A bad shift direction or a missed top-end feed distorts every window sum by the end of the add-and-shift run. Stack pointer errors show up one pop later as a wrong bit on `flag_top`. Arithmetic that wraps instead of clamping makes an accumulator drop below its earlier value within one cycle.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_CLR   = 4'd1,
    OP_LDDR  = 4'd2,
    OP_ADDSH = 4'd3,
    OP_ADDCG = 4'd4,
    OP_WIN   = 4'd5,
    OP_CMP   = 4'd6,
    OP_POP   = 4'd7,
    OP_MWR   = 4'd8,
    OP_MADD  = 4'd9,
    OP_MSUB  = 4'd10,
    OP_SRST  = 4'd11
  } op_e;

  typedef struct packed {
    logic clr;
    logic lddr;
    logic addsh;
    logic addcg;
    logic win;
    logic cmp;
    logic pop;
    logic mwr;
    logic madd;
    logic msub;
    logic srst;
  } ctl_t;
endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
  import dpc_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    if (valid) begin
      unique case (op)
        OP_CLR:   ctl.clr   = 1'b1;
        OP_LDDR:  ctl.lddr  = 1'b1;
        OP_ADDSH: ctl.addsh = 1'b1;
        OP_ADDCG: ctl.addcg = 1'b1;
        OP_WIN:   ctl.win   = 1'b1;
        OP_CMP:   ctl.cmp   = 1'b1;
        OP_POP:   ctl.pop   = 1'b1;
        OP_MWR:   ctl.mwr   = 1'b1;
        OP_MADD:  ctl.madd  = 1'b1;
        OP_MSUB:  ctl.msub  = 1'b1;
        OP_SRST:  ctl.srst  = 1'b1;
        default:  ctl       = '0;
      endcase
    end
  end
endmodule

// File: rtl/dpc_flag_stack.sv
module dpc_flag_stack #(
  parameter int SDEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic pop,
  input  logic din,
  output logic top
);
  localparam int PTRW = $clog2(SDEPTH + 1);

  logic [SDEPTH-1:0] bits_q;
  logic [PTRW-1:0]   ptr_q;

  assign top = (ptr_q == '0) ? 1'b0 : bits_q[ptr_q - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      ptr_q  <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (push) begin
      if (ptr_q < PTRW'(SDEPTH)) begin
        bits_q[ptr_q] <= din;
        ptr_q         <= ptr_q + 1'b1;
      end
    end else if (pop && ptr_q != '0) begin
      ptr_q <= ptr_q - 1'b1;
    end
  end

  p_ptr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTRW'(SDEPTH));
  p_pop_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && ptr_q != '0) |=> ptr_q == $past(ptr_q) - 1'b1);
endmodule

// File: rtl/dpc_pe.sv
module dpc_pe
  import dpc_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int CW     = 12,
  parameter int NTYPE  = 4,
  parameter int SDEPTH = 8,
  parameter int TW     = 2,
  parameter int PW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [TW-1:0] sel_type,
  input  logic [PW-1:0] sel_pe,
  input  logic [CW-1:0] imm,
  input  logic [PW-1:0] win_lo,
  input  logic [PW-1:0] win_hi,
  input  logic          win_seed,
  input  logic [CW-1:0] ctg,
  input  logic [CW-1:0] up_dat,
  input  logic          up_tok,
  output logic [CW-1:0] dn_dat,
  output logic          dn_tok,
  output logic [CW-1:0] acc,
  output logic          flag
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] acc_q, dr_q;
  logic [CW-1:0] mem_q [NTYPE];
  logic          tok_q, en_q;
  logic          exec, le, me;
  logic [CW-1:0] minv, add_src;
  logic [CW:0]   sum, msum;
  logic [CW:0]   mdif;

  assign me      = (sel_pe == PW'(IDX));
  assign exec    = ctl.cmp && tok_q;
  assign le      = (acc_q <= dr_q);
  assign minv    = le ? acc_q : dr_q;
  assign dn_dat  = exec ? minv : dr_q;
  assign dn_tok  = exec;
  assign acc     = acc_q;
  assign add_src = ctl.addcg ? ctg : dr_q;
  assign sum     = {1'b0, acc_q} + {1'b0, add_src};
  assign msum    = {1'b0, mem_q[sel_type]} + {1'b0, imm};
  assign mdif    = {1'b0, mem_q[sel_type]} - {1'b0, imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (ctl.clr) begin
      acc_q <= '0;
    end else if (ctl.addsh || ctl.addcg) begin
      acc_q <= sum[CW] ? CMAX : sum[CW-1:0];
    end else if (exec) begin
      acc_q <= minv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else if (ctl.lddr) begin
      dr_q <= mem_q[sel_type];
    end else if (ctl.addsh) begin
      dr_q <= up_dat;
    end else if (ctl.win && win_seed && win_hi == PW'(IDX)) begin
      dr_q <= CMAX;
    end else if (up_tok && en_q) begin
      dr_q <= up_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (ctl.win) begin
      en_q  <= (PW'(IDX) >= win_lo) && (PW'(IDX) <= win_hi);
      tok_q <= win_seed && (win_hi == PW'(IDX));
    end else begin
      tok_q <= (tok_q && !ctl.cmp) || (up_tok && en_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTYPE; t++) mem_q[t] <= '0;
    end else if (me) begin
      if (ctl.mwr)       mem_q[sel_type] <= imm;
      else if (ctl.madd) mem_q[sel_type] <= msum[CW] ? CMAX : msum[CW-1:0];
      else if (ctl.msub) mem_q[sel_type] <= mdif[CW] ? '0 : mdif[CW-1:0];
    end
  end

  dpc_flag_stack #(.SDEPTH(SDEPTH)) i_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctl.srst),
    .push (exec),
    .pop  (ctl.pop),
    .din  (le),
    .top  (flag)
  );

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.addsh || ctl.addcg) && !ctl.clr |=> acc_q >= $past(acc_q));
  p_cmp_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> (acc_q <= $past(acc_q)) && (acc_q <= $past(dr_q)));
  p_idle_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cmp && !tok_q) |=> $stable(acc_q));
endmodule

// File: rtl/dpc_array.sv
module dpc_array
  import dpc_pkg::*;
#(
  parameter int NPE    = 16,
  parameter int CW     = 12,
  parameter int NTYPE  = 4,
  parameter int SDEPTH = 8,
  parameter int TW     = $clog2(NTYPE),
  parameter int PW     = $clog2(NPE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [3:0]        ins_op,
  input  logic [TW-1:0]     ins_type,
  input  logic [PW-1:0]     ins_pe,
  input  logic [CW-1:0]     ins_dat,
  input  logic [NPE*CW-1:0] ctg_flat,
  input  logic [CW-1:0]     casc_hi_dat,
  input  logic              casc_hi_tok,
  output logic [CW-1:0]     casc_lo_dat,
  output logic              casc_lo_tok,
  output logic [NPE*CW-1:0] acc_flat,
  output logic [NPE-1:0]    flag_top
);
  ctl_t          ctl;
  logic [CW-1:0] dn_dat [NPE];
  logic [NPE-1:0] dn_tok;
  logic [CW-1:0] lo_dat_q;
  logic          lo_tok_q;

  assign ins_ready   = 1'b1;
  assign casc_lo_dat = lo_dat_q;
  assign casc_lo_tok = lo_tok_q;

  dpc_decode i_dec (.valid(ins_valid), .op(ins_op), .ctl(ctl));

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    logic [CW-1:0] up_d;
    logic          up_t;
    if (g == NPE - 1) begin : g_top
      assign up_d = casc_hi_dat;
      assign up_t = casc_hi_tok;
    end else begin : g_mid
      assign up_d = dn_dat[g+1];
      assign up_t = dn_tok[g+1];
    end
    dpc_pe #(
      .IDX(g), .CW(CW), .NTYPE(NTYPE), .SDEPTH(SDEPTH), .TW(TW), .PW(PW)
    ) i_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .sel_type(ins_type),
      .sel_pe  (ins_pe),
      .imm     (ins_dat),
      .win_lo  (ins_dat[PW-1:0]),
      .win_hi  (ins_pe),
      .win_seed(ins_dat[CW-1]),
      .ctg     (ctg_flat[g*CW +: CW]),
      .up_dat  (up_d),
      .up_tok  (up_t),
      .dn_dat  (dn_dat[g]),
      .dn_tok  (dn_tok[g]),
      .acc     (acc_flat[g*CW +: CW]),
      .flag    (flag_top[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_dat_q <= '0;
      lo_tok_q <= 1'b0;
    end else begin
      lo_tok_q <= dn_tok[0];
      if (ctl.addsh || dn_tok[0]) lo_dat_q <= dn_dat[0];
    end
  end

  p_tok_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_tok));
  p_lo_tok_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_lo_tok |=> !casc_lo_tok);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(acc_flat));
endmodule

// File: tb/test_dpc_array.sv
module test_dpc_array;
  localparam int NPE = 16, CW = 12, NTYPE = 4, SDEPTH = 8;
  localparam int TW = 2, PW = 4;
  localparam time TCLK = 10ns;
  localparam int MAXV = 4095;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [3:0] ins_op = '0;
  logic [TW-1:0] ins_type = '0;
  logic [PW-1:0] ins_pe = '0;
  logic [CW-1:0] ins_dat = '0;
  logic [NPE*CW-1:0] ctg_flat = '0;
  logic [CW-1:0] casc_hi_dat = '0, casc_lo_dat;
  logic casc_hi_tok = 1'b0, casc_lo_tok;
  logic [NPE*CW-1:0] acc_flat;
  logic [NPE-1:0] flag_top;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  dpc_array i_dpc_array (.*);

  function automatic int acc_of(int i);
    return int'(acc_flat[i*CW +: CW]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(int op, int ty, int pe, int dat, bit vld = 1'b1);
    ins_op = 4'(op); ins_type = TW'(ty); ins_pe = PW'(pe); ins_dat = CW'(dat);
    ins_valid = vld;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic set_acc(int v[NPE]);
    issue(1, 0, 0, 0);
    for (int i = 0; i < NPE; i++) ctg_flat[i*CW +: CW] = CW'(v[i]);
    issue(4, 0, 0, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NPE; i++) chk("R1 acc", acc_of(i), 0);
    chk("R1 flags", int'(flag_top), 0);
    chk("R1 lo_tok", int'(casc_lo_tok), 0);
    chk("R1 lo_dat", int'(casc_lo_dat), 0);
    chk("R1 ready", int'(ins_ready), 1);
  endtask

  task automatic t_window_sum();
    int exp;
    for (int i = 0; i < NPE; i++) issue(8, 1, i, i + 1);
    casc_hi_dat = 5;
    issue(1, 0, 0, 0);
    issue(2, 1, 0, 0);
    for (int k = 0; k < 3; k++) issue(3, 0, 0, 0);
    for (int i = 0; i < NPE; i++) begin
      exp = 0;
      for (int k = 0; k < 3; k++) exp += (i + k < NPE) ? i + k + 1 : 5;
      chk("R2 R3 window sum", acc_of(i), exp);
    end
    chk("R3 casc_lo_dat", int'(casc_lo_dat), 3);
    issue(1, 0, 0, 0, 1'b0);
    chk("R12 invalid clear ignored", acc_of(0), 6);
    casc_hi_dat = 0;
  endtask

  task automatic t_ctg();
    int base[NPE];
    for (int i = 0; i < NPE; i++) base[i] = acc_of(i);
    for (int i = 0; i < NPE; i++) ctg_flat[i*CW +: CW] = CW'(10 * i);
    issue(4, 0, 0, 0);
    for (int i = 0; i < NPE; i += 5) chk("R5 ctg add", acc_of(i), base[i] + 10 * i);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < NPE; i++) ctg_flat[i*CW +: CW] = CW'(3000);
    issue(1, 0, 0, 0);
    issue(4, 0, 0, 0);
    issue(4, 0, 0, 0);
    chk("R4 saturate", acc_of(7), MAXV);
    issue(8, 3, 2, 4090);
    issue(9, 3, 2, 100);
    issue(1, 0, 0, 0);
    issue(2, 3, 0, 0);
    issue(3, 0, 0, 0);
    chk("R11 add clamp", acc_of(2), MAXV);
    issue(10, 3, 2, 4095);
    issue(9, 3, 2, 7);
    issue(10, 3, 2, 9);
    issue(1, 0, 0, 0);
    issue(2, 3, 0, 0);
    issue(3, 0, 0, 0);
    chk("R11 sub floor", acc_of(2), 0);
  endtask

  task automatic t_chain_mid();
    int c[NPE];
    for (int i = 0; i < NPE; i++) c[i] = 500;
    c[7] = 9; c[6] = 4; c[5] = 4; c[4] = 7; c[3] = 2;
    set_acc(c);
    issue(11, 0, 0, 0);
    issue(5, 0, 7, 2048 + 3);
    for (int k = 0; k < 5; k++) issue(6, 0, 0, 0);
    chk("R7 acc7", acc_of(7), 9);
    chk("R7 acc6", acc_of(6), 4);
    chk("R7 acc4 carries min", acc_of(4), 4);
    chk("R7 acc3", acc_of(3), 2);
    chk("R6 R7 flags incl tie", int'(flag_top), 16'b0000_0000_1110_1000);
    issue(6, 0, 0, 0);
    chk("R7 chain ended", acc_of(2), 500);
    chk("R7 no lo tok", int'(casc_lo_tok), 0);
    issue(7, 0, 0, 0);
    chk("R10 pop empty", int'(flag_top), 0);
  endtask

  task automatic t_chain_low();
    int c[NPE];
    for (int i = 0; i < NPE; i++) c[i] = 0;
    c[2] = 5; c[1] = 8; c[0] = 3;
    set_acc(c);
    issue(5, 0, 2, 2048);
    for (int k = 0; k < 3; k++) issue(6, 0, 0, 0);
    chk("R8 lo tok pulse", int'(casc_lo_tok), 1);
    chk("R8 lo dat min", int'(casc_lo_dat), 3);
    issue(0, 0, 0, 0);
    chk("R8 pulse ends", int'(casc_lo_tok), 0);
    c[1] = 1;
    set_acc(c);
    issue(5, 0, 2, 2048);
    for (int k = 0; k < 3; k++) issue(6, 0, 0, 0);
    chk("R8 lo dat 2", int'(casc_lo_dat), 1);
    chk("R10 top after 2 runs", int'(flag_top[2:0]), 3'b110);
    issue(7, 0, 0, 0);
    chk("R10 LIFO pop", int'(flag_top[2:0]), 3'b101);
    issue(7, 0, 0, 0);
    chk("R10 pop to empty", int'(flag_top[2:0]), 0);
  endtask

  task automatic t_hi_in();
    int c[NPE];
    for (int i = 0; i < NPE; i++) c[i] = 50;
    set_acc(c);
    issue(11, 0, 0, 0);
    for (int k = 0; k < SDEPTH; k++) begin
      issue(5, 0, 15, 2048 + 15);
      issue(6, 0, 0, 0);
    end
    issue(5, 0, 15, 15);
    casc_hi_tok = 1'b1; casc_hi_dat = 0;
    issue(0, 0, 0, 0);
    casc_hi_tok = 1'b0;
    issue(6, 0, 0, 0);
    chk("R9 hi token used", acc_of(15), 0);
    chk("R10 full push dropped", int'(flag_top[15]), 1);
    chk("R9 token stops", acc_of(14), 50);
    issue(11, 0, 0, 0);
    set_acc(c);
    issue(5, 0, 15, 15);
    casc_hi_tok = 1'b1; casc_hi_dat = 0;
    issue(0, 0, 0, 0);
    casc_hi_tok = 1'b0;
    issue(6, 0, 0, 0);
    chk("R9 flag zero", int'(flag_top[15]), 0);
    chk("R10 srst emptied", int'(flag_top[7]), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window_sum();
    t_ctg();
    t_saturate();
    t_chain_mid();
    t_chain_low();
    t_hi_in();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule